// File: doc/BRIEF.md
# Multi-Range PWM Channel Generator

This block drives one pulse-width-modulated output whose rate is chosen by an 8-bit frequency word. The word is split into a 2-bit range selector and a 6-bit multiplier. Each range has a fixed frequency step: 0.5 Hz, 2 Hz, 8 Hz and 32 Hz for ranges 0 to 3. The output frequency is the multiplier plus one, times that step. Across all four ranges the block covers 0.5 Hz to 2048 Hz. A second 8-bit word sets the duty, and two single-bit controls select output inversion and enable the channel.

A free-running prescaler, clocked by the fixed reference clock, produces one tick per range. Each range ticks four times as often as the range below it. On every tick of the selected range, a 14-bit phase accumulator adds (multiplier + 1). The upper eight phase bits split each period into 256 duty slots. The output is registered. Configuration inputs are used as they arrive, with no shadowing and no restart of the phase, so a change made mid-period shapes the rest of that period. A top level would place four of these channels side by side, sharing one configuration path.

Top module: `pwmr_channel`

## Requirements
- R1: The range-s tick fires once every 2^(DIV3_LOG2 + 2*(3-s)) reference cycles. The slower ticks always coincide with the faster ones.
- R2: `freq_cfg[7:6]` selects the range and `freq_cfg[5:0]` holds the multiplier c. One period lasts 16384/(c+1) ticks of the selected range, which gives exactly one rising edge per period.
- R3: With duty code d, the output is active for d+1 of the 256 slots in each period. Code 0 still gives one active slot, and code 255 keeps the output active for the whole period.
- R4: While the channel is enabled, setting `pol_inv` complements the output, taking effect on the next clock edge.
- R5: While `chan_en` is low, and during reset, `pwm_out` is low whatever `pol_inv` is set to, and the phase is held at slot 0.
- R6: When `chan_en` rises, the period starts at slot 0. The output is active one clock edge after the first enabled edge, and it falls after d+1 slots.
- R7: A change to `duty_cfg` in mid-period acts on the next clock edge, without restarting the phase.
- R8: A change to `freq_cfg` in mid-period alters only the rate of phase advance, never its value. The slot moves forward by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; output held low when 0 |
| pol_inv | input | 1 | Output inversion while enabled |
| freq_cfg | input | 8 | [7:6] range selector, [5:0] multiplier |
| duty_cfg | input | 8 | Duty code, active for code+1 of 256 slots |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a configuration change that lands at a known slot in the middle of a period. The phase is not visible, and the block does not restart it on a write. The stimulus therefore enables the channel in the fastest range with multiplier 63, where the slot advances by exactly one per clock, and then counts edges. This places duty, inversion and frequency writes at chosen slots and shows that the phase carries on rather than restarting. The steady-state rows count active cycles and rising edges over exactly one period, so the measurement does not depend on where in the period the window starts.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
    localparam int unsigned SLOT_W = 8;
    localparam int unsigned MULT_W = 6;
    localparam int unsigned PH_W   = SLOT_W + MULT_W;
    localparam int unsigned RANGES = 4;
    localparam int unsigned RSEL_W = $clog2(RANGES);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } phase_st_t;

    typedef struct packed {
        logic pwm;
    } out_st_t;
endpackage

// File: rtl/pwmr_prescaler.sv
module pwmr_prescaler
    import pwmr_pkg::*;
#(
    parameter int unsigned DIV3_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [RANGES-1:0] tick
);
    localparam int unsigned PS_W = DIV3_LOG2 + 2 * (RANGES - 1);

    logic [PS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + PS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // each range ticks when its low-order counter bits are all ones
    for (genvar s = 0; s < RANGES; s++) begin : g_tick
        localparam int unsigned    SH   = DIV3_LOG2 + 2 * (RANGES - 1 - s);
        localparam logic [PS_W-1:0] MASK = ~({PS_W{1'b1}} << SH);
        assign tick[s] = ((cnt_q & MASK) == MASK);
    end
endmodule

// File: rtl/pwmr_phase.sv
module pwmr_phase
    import pwmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RANGES-1:0] tick,
    input  logic [RSEL_W-1:0] rsel,
    input  logic [MULT_W-1:0] mult,
    output logic [SLOT_W-1:0] slot
);
    phase_st_t       st_d, st_q;
    logic [PH_W-1:0] inc;

    always_comb begin
        inc  = PH_W'(mult) + PH_W'(1);
        st_d = st_q;
        if (!en) begin
            st_d.phase = '0;
        end else if (tick[rsel]) begin
            st_d.phase = st_q.phase + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot = st_q.phase[PH_W-1 -: SLOT_W];
endmodule

// File: rtl/pwmr_outstage.sv
module pwmr_outstage
    import pwmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              inv,
    input  logic [SLOT_W-1:0] duty,
    input  logic [SLOT_W-1:0] slot,
    output logic              pwm
);
    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwm = en & ((slot <= duty) ^ inv);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.pwm;
endmodule

// File: rtl/pwmr_channel.sv
module pwmr_channel
    import pwmr_pkg::*;
#(
    parameter int unsigned DIV3_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       pol_inv,
    input  logic [7:0] freq_cfg,
    input  logic [7:0] duty_cfg,
    output logic       pwm_out
);
    logic [RANGES-1:0] range_tick;
    logic [SLOT_W-1:0] slot_w;
    logic [RSEL_W-1:0] rsel_w;
    logic [MULT_W-1:0] mult_w;

    assign rsel_w = freq_cfg[7:6];
    assign mult_w = freq_cfg[5:0];

    pwmr_prescaler #(.DIV3_LOG2(DIV3_LOG2)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (range_tick)
    );

    pwmr_phase i_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (chan_en),
        .tick (range_tick),
        .rsel (rsel_w),
        .mult (mult_w),
        .slot (slot_w)
    );

    pwmr_outstage i_out (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (chan_en),
        .inv  (pol_inv),
        .duty (duty_cfg),
        .slot (slot_w),
        .pwm  (pwm_out)
    );
endmodule

// File: rtl/pwmr_channel_chk.sv
module pwmr_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chan_en,
    input logic       pol_inv,
    input logic [7:0] duty_cfg,
    input logic       pwm_out,
    input logic [3:0] tick,
    input logic [7:0] slot
);
    // R5
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !pwm_out);

    // R5
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (slot == 8'd0));

    // R3
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !pol_inv && duty_cfg == 8'hFF) |=> pwm_out);

    // R4
    inv_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && pol_inv && duty_cfg == 8'hFF) |=> !pwm_out);

    // R1
    tick_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[0] |-> (tick[1] && tick[2] && tick[3]));

    // R1
    tick_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[2] |-> tick[3]);

    // R6
    enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chan_en) && !pol_inv) |=> pwm_out);

    // R8
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && $past(chan_en)) |->
            (slot == $past(slot) || slot == 8'($past(slot) + 8'd1)));
endmodule

bind pwmr_channel pwmr_channel_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_en (chan_en),
    .pol_inv (pol_inv),
    .duty_cfg(duty_cfg),
    .pwm_out (pwm_out),
    .tick    (range_tick),
    .slot    (slot_w)
);

// File: tb/test_pwmr_channel.sv
module test_pwmr_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       pol_inv = 1'b0;
    logic [7:0] freq_cfg = 8'hFF;
    logic [7:0] duty_cfg = 8'd0;
    logic       pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // range-3 tick every cycle; range s every 4^(3-s) cycles
    pwmr_channel #(.DIV3_LOG2(0)) i_pwmr_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .pol_inv (pol_inv),
        .freq_cfg(freq_cfg),
        .duty_cfg(duty_cfg),
        .pwm_out (pwm_out)
    );

    typedef struct packed {
        logic [1:0]  rng;
        logic [5:0]  mult;
        logic [7:0]  duty;
        logic        inv;
        logic        en;
        logic [15:0] per;
        logic [15:0] high;
        logic [1:0]  rises;
    } vec_t;

    // per = 16384/(c+1) * 4^(3-s) cycles; high = (d+1)*64/(c+1) ticks
    localparam vec_t VECS [12] = '{
        '{2'd3, 6'd63, 8'd0,   1'b0, 1'b1, 16'd256,   16'd1,    2'd1},
        '{2'd3, 6'd63, 8'd127, 1'b0, 1'b1, 16'd256,   16'd128,  2'd1},
        '{2'd3, 6'd63, 8'd255, 1'b0, 1'b1, 16'd256,   16'd256,  2'd0},
        '{2'd3, 6'd31, 8'd63,  1'b0, 1'b1, 16'd512,   16'd128,  2'd1},
        '{2'd2, 6'd63, 8'd9,   1'b0, 1'b1, 16'd1024,  16'd40,   2'd1},
        '{2'd3, 6'd63, 8'd63,  1'b1, 1'b1, 16'd256,   16'd192,  2'd1},
        '{2'd3, 6'd63, 8'd255, 1'b1, 1'b1, 16'd256,   16'd0,    2'd0},
        '{2'd3, 6'd63, 8'd100, 1'b0, 1'b0, 16'd256,   16'd0,    2'd0},
        '{2'd3, 6'd63, 8'd100, 1'b1, 1'b0, 16'd256,   16'd0,    2'd0},
        '{2'd1, 6'd63, 8'd31,  1'b0, 1'b1, 16'd4096,  16'd512,  2'd1},
        '{2'd0, 6'd63, 8'd3,   1'b0, 1'b1, 16'd16384, 16'd256,  2'd1},
        '{2'd3, 6'd0,  8'd0,   1'b0, 1'b1, 16'd16384, 16'd64,   2'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int hi;
        int rs;
        logic prev;
        edges(4);
        check("R5 reset low", int'(pwm_out), 0);
        rst_n = 1'b1;
        edges(3);
        check("R5 disabled after reset", int'(pwm_out), 0);

        // R6 / R3: start from slot 0, one slot per clock
        freq_cfg = {2'd3, 6'd63};
        duty_cfg = 8'd10;
        pol_inv  = 1'b0;
        chan_en  = 1'b1;
        edges(1);
        check("R6 active after first edge", int'(pwm_out), 1);
        edges(10);
        check("R3 active on slot d", int'(pwm_out), 1);
        edges(1);
        check("R3 inactive after d+1 slots", int'(pwm_out), 0);

        // R7: duty change mid-period acts next edge
        edges(38);
        check("R7 low before duty write", int'(pwm_out), 0);
        duty_cfg = 8'd200;
        edges(1);
        check("R7 high after duty write", int'(pwm_out), 1);
        // R4: inversion acts next edge
        pol_inv = 1'b1;
        edges(1);
        check("R4 inverted next edge", int'(pwm_out), 0);
        pol_inv = 1'b0;

        // R8: frequency change keeps phase
        chan_en = 1'b0;
        edges(2);
        check("R5 disabled low", int'(pwm_out), 0);
        duty_cfg = 8'd30;
        chan_en  = 1'b1;
        edges(101);
        check("R8 low at slot 100", int'(pwm_out), 0);
        freq_cfg = {2'd3, 6'd62};
        edges(1);
        check("R8 no restart after freq write", int'(pwm_out), 0);
        edges(98);
        check("R8 still low later in period", int'(pwm_out), 0);

        // steady-state table, R1 R2 R3 R4 R5
        for (int v = 0; v < 12; v++) begin
            freq_cfg = {VECS[v].rng, VECS[v].mult};
            duty_cfg = VECS[v].duty;
            pol_inv  = VECS[v].inv;
            chan_en  = VECS[v].en;
            edges(8);
            hi = 0;
            rs = 0;
            prev = pwm_out;
            for (int c = 0; c < int'(VECS[v].per); c++) begin
                edges(1);
                if (pwm_out) hi++;
                if (pwm_out && !prev) rs++;
                prev = pwm_out;
            end
            check($sformatf("R3 R4 R5 high cycles row %0d", v), hi, int'(VECS[v].high));
            check($sformatf("R1 R2 rising edges row %0d", v), rs, int'(VECS[v].rises));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule